// File: doc/BRIEF.md
# Nibble-Multiplexed Sample Output Stage

This block sits at the digital end of a pixel-rate sampling chain. Once per pixel period it accepts a 16-bit unsigned sample word, marked by a one-cycle valid pulse aligned to the pixel strobe. It then drives that word onto a 4-bit bus as four consecutive nibbles, most significant first. Each nibble is held for one master-clock cycle.

The word may be inverted in polarity on capture. Its appearance on the bus can be delayed by a programmable number of converter-clock periods. One converter-clock period is two master clocks in the normal mode and three in the fast mode. A test setting replaces the data nibbles with four internal timing strobes, so that the sampling rhythm can be observed on the data pins.

Words that arrive closer together than four cycles are queued in a one-word staging register, so a word never breaks into the middle of another. After the last nibble the bus keeps that nibble until the next word starts. Before the first word after reset the bus shows zero.

Top module: `nibble_out_stage`

## Requirements
- R1: The captured word leaves the bus as four nibbles on four consecutive cycles, in the order bits 15..12, 11..8, 7..4, 3..0.
- R2: Within every nibble, bus bit 0 carries the lowest bit of the nibble and bus bit 3 the highest, so bus bit 3 shows bits 15, 11, 7 and 3 in turn.
- R3: With a delay field of 0, the first nibble appears on the bus one master clock after the edge that captures the valid pulse. Until then the bus keeps its previous value.
- R4: In normal mode (`cfg_fast` = 0), each unit of the 2-bit `cfg_delay` field adds 2 master clocks to the latency of R3.
- R5: In fast mode (`cfg_fast` = 1), each unit of `cfg_delay` adds 3 master clocks to the latency of R3.
- R6: When `cfg_invert` is 1 at the capture edge, the word put out is 65535 minus the input word. When it is 0, the word passes through unchanged.
- R7: When `cfg_test` is 1, the bus shows strobes instead of data, and clearing it brings the data nibble back at once:
  - bit 3 is the internal pixel strobe, high for the cycle after a capture edge;
  - bit 2 is the video sample strobe, one cycle after the pixel strobe;
  - bit 1 is the converter clock, high on phase 0 of a phase counter that restarts at 0 on each capture edge and wraps at the converter-clock length;
  - bit 0 is the reset sample strobe, high on the last phase of that counter.
- R8: From reset until the first word reaches the bus, the bus is zero.
- R9: A word that reaches its output time while another word is still being shifted out is staged. Its first nibble then follows the previous word's last nibble on the next cycle, with no nibble lost or interleaved.
- R10: After the last nibble of a word, the bus holds that nibble until the next word begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset |
| smp_valid | input | 1 | One-cycle pulse marking a new sample word |
| smp_word | input | 16 | Unsigned sample word |
| cfg_invert | input | 1 | Output polarity inversion |
| cfg_fast | input | 1 | Fast mode: 3 master clocks per converter clock instead of 2 |
| cfg_delay | input | 2 | Extra latency in converter-clock periods |
| cfg_test | input | 1 | Replace data with internal timing strobes |
| nib_out | output | 4 | Multiplexed nibble bus |

## Verification
The bench checks the cycle just before each first nibble as well as the nibble itself. A latency that is off by one master clock, or that scales by the wrong converter-clock length in fast mode, then shows up as a wrong value. Asymmetric words such as A5C3 and 8421 expose a reversed nibble order or a swapped bit order within a nibble. Two words sent two cycles apart show whether a late word tears into the one still being shifted, or gets dropped. The strobe patterns are checked in both modes, because a phase counter that ignores the mode or fails to restart at the pixel strobe puts the converter-clock and reset-sample bits in the wrong cycles.

// File: rtl/nos_pkg.sv
package nos_pkg;
   // Test-mode strobe bundle; field order is the bus bit order (bit 3 first).
   typedef struct packed {
      logic pix;   // bus bit 3: internal pixel strobe
      logic vs;    // bus bit 2: video sample strobe
      logic conv;  // bus bit 1: converter clock
      logic rs;    // bus bit 0: reset sample strobe
   } nos_strobe_t;
endpackage

// File: rtl/nos_delay_line.sv
module nos_delay_line #(
   parameter int W     = 16,
   parameter int DEPTH = 10,
   parameter int SEL_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_v,
   input  logic [W-1:0]     in_d,
   input  logic [SEL_W-1:0] sel,
   output logic             out_v,
   output logic [W-1:0]     out_d
);
   logic [DEPTH-1:0] v_q;
   logic [W-1:0]     d_q [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_stage
      if (g == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               v_q[0] <= 1'b0;
               d_q[0] <= '0;
            end else begin
               v_q[0] <= in_v;
               d_q[0] <= in_d;
            end
         end
      end else begin : g_body
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               v_q[g] <= 1'b0;
               d_q[g] <= '0;
            end else begin
               v_q[g] <= v_q[g-1];
               d_q[g] <= d_q[g-1];
            end
         end
      end
   end

   always_comb begin
      out_v = 1'b0;
      out_d = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (32'(sel) == i) begin
            out_v = v_q[i];
            out_d = d_q[i];
         end
      end
   end
endmodule

// File: rtl/nos_serializer.sv
module nos_serializer #(
   parameter int W = 16,
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_v,
   input  logic [W-1:0] in_d,
   output logic [N-1:0] nib_q
);
   localparam int NUM   = W / N;
   localparam int IDX_W = $clog2(NUM);

   logic [W-1:0]     sh_q;
   logic [IDX_W-1:0] idx_q;
   logic             busy_q;
   logic             stg_v_q;
   logic [W-1:0]     stg_d_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q    <= '0;
         idx_q   <= '0;
         busy_q  <= 1'b0;
         stg_v_q <= 1'b0;
         stg_d_q <= '0;
         nib_q   <= '0;
      end else if (!busy_q) begin
         if (stg_v_q) begin
            nib_q   <= stg_d_q[W-1 -: N];
            sh_q    <= stg_d_q;
            idx_q   <= IDX_W'(1);
            busy_q  <= 1'b1;
            stg_v_q <= in_v;
            stg_d_q <= in_v ? in_d : stg_d_q;
         end else if (in_v) begin
            nib_q  <= in_d[W-1 -: N];
            sh_q   <= in_d;
            idx_q  <= IDX_W'(1);
            busy_q <= 1'b1;
         end
      end else begin
         nib_q <= sh_q[(NUM-1-32'(idx_q))*N +: N];
         idx_q <= idx_q + 1'b1;
         if (32'(idx_q) == NUM-1) busy_q <= 1'b0;
         if (in_v) begin
            stg_v_q <= 1'b1;
            stg_d_q <= in_d;
         end
      end
   end
endmodule

// File: rtl/nos_strobe_gen.sv
module nos_strobe_gen
   import nos_pkg::*;
#(
   parameter int PH_W     = 2,
   parameter int SLOW_LEN = 2,
   parameter int FAST_LEN = 3
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        px_in,
   input  logic        fast,
   output nos_strobe_t strb
);
   logic [PH_W-1:0] ph_q;
   logic            pix_q;
   logic            vs_q;
   int              len;

   assign len = fast ? FAST_LEN : SLOW_LEN;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= '0;
         pix_q <= 1'b0;
         vs_q  <= 1'b0;
      end else begin
         pix_q <= px_in;
         vs_q  <= pix_q;
         if (px_in || 32'(ph_q) >= len - 1) ph_q <= '0;
         else                               ph_q <= ph_q + 1'b1;
      end
   end

   always_comb begin
      strb.pix  = pix_q;
      strb.vs   = vs_q;
      strb.conv = (ph_q == '0);
      strb.rs   = (32'(ph_q) == len - 1);
   end
endmodule

// File: rtl/nibble_out_stage.sv
module nibble_out_stage
   import nos_pkg::*;
#(
   parameter int WORD_W   = 16,
   parameter int NIB_W    = 4,
   parameter int DLY_W    = 2,
   parameter int SLOW_LEN = 2,
   parameter int FAST_LEN = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_valid,
   input  logic [WORD_W-1:0] smp_word,
   input  logic              cfg_invert,
   input  logic              cfg_fast,
   input  logic [DLY_W-1:0]  cfg_delay,
   input  logic              cfg_test,
   output logic [NIB_W-1:0]  nib_out
);
   localparam int MAX_LAT = ((1 << DLY_W) - 1) * FAST_LEN;
   localparam int DEPTH   = MAX_LAT + 1;
   localparam int LAT_W   = $clog2(DEPTH + 1);
   localparam int PH_W    = $clog2(FAST_LEN + 1);

   if (WORD_W % NIB_W != 0)       begin : g_bad_split $error("WORD_W must be a multiple of NIB_W"); end
   if (WORD_W / NIB_W < 2)        begin : g_bad_count $error("at least two nibbles per word"); end
   if (NIB_W < 4)                 begin : g_bad_nib   $error("NIB_W must hold the four strobes"); end
   if (SLOW_LEN < 1 || FAST_LEN < SLOW_LEN) begin : g_bad_len $error("bad converter-clock lengths"); end

   logic [WORD_W-1:0] cap_d;
   logic [LAT_W-1:0]  tap_sel;
   logic              tap_v;
   logic [WORD_W-1:0] tap_d;
   logic [NIB_W-1:0]  data_nib;
   nos_strobe_t       strb;

   assign cap_d   = cfg_invert ? ~smp_word : smp_word;
   assign tap_sel = LAT_W'(32'(cfg_delay) * (cfg_fast ? FAST_LEN : SLOW_LEN));

   nos_delay_line #(.W(WORD_W), .DEPTH(DEPTH), .SEL_W(LAT_W)) dly_i (
      .clk(clk), .rst_n(rst_n), .in_v(smp_valid), .in_d(cap_d),
      .sel(tap_sel), .out_v(tap_v), .out_d(tap_d));

   nos_serializer #(.W(WORD_W), .N(NIB_W)) ser_i (
      .clk(clk), .rst_n(rst_n), .in_v(tap_v), .in_d(tap_d), .nib_q(data_nib));

   nos_strobe_gen #(.PH_W(PH_W), .SLOW_LEN(SLOW_LEN), .FAST_LEN(FAST_LEN)) stb_i (
      .clk(clk), .rst_n(rst_n), .px_in(smp_valid), .fast(cfg_fast), .strb(strb));

   if (NIB_W == 4) begin : g_mux_exact
      assign nib_out = cfg_test ? NIB_W'(strb) : data_nib;
   end else begin : g_mux_pad
      assign nib_out = cfg_test ? {{(NIB_W-4){1'b0}}, strb} : data_nib;
   end
endmodule

// File: rtl/nos_checker.sv
module nos_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        smp_valid,
   input logic [15:0] smp_word,
   input logic        cfg_invert,
   input logic        cfg_fast,
   input logic [1:0]  cfg_delay,
   input logic        cfg_test,
   input logic [3:0]  nib_out
);
   logic seen_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         seen_q <= 1'b0;
      else if (smp_valid) seen_q <= 1'b1;
   end

   // R8: zero before any word was captured
   a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (!seen_q && !cfg_test) |-> nib_out == 4'h0);

   // R1, R3, R6: first nibble one clock after an isolated capture with zero delay
   a_r3_first_nibble: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(smp_valid, 2) && $past(cfg_delay, 2) == 2'd0 && !cfg_test &&
       !$past(smp_valid, 3) && !$past(smp_valid, 4) && !$past(smp_valid, 5))
      |-> nib_out == ($past(cfg_invert, 2) ? ~$past(smp_word[15:12], 2)
                                            :  $past(smp_word[15:12], 2)));

   // R1: second nibble follows on the next clock
   a_r1_second_nibble: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(smp_valid, 3) && $past(cfg_delay, 3) == 2'd0 && !cfg_test &&
       !$past(smp_valid, 4) && !$past(smp_valid, 5) && !$past(smp_valid, 6))
      |-> nib_out == ($past(cfg_invert, 3) ? ~$past(smp_word[11:8], 3)
                                            :  $past(smp_word[11:8], 3)));

   // R7: pixel strobe on bit 3 in test mode
   a_r7_test_pixel: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_test |-> nib_out[3] == $past(smp_valid));

   // R7: video sample strobe on bit 2 one cycle later
   a_r7_test_video: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_test |-> nib_out[2] == $past(smp_valid, 2));
endmodule

bind nibble_out_stage nos_checker chk_i (
   .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_word(smp_word),
   .cfg_invert(cfg_invert), .cfg_fast(cfg_fast), .cfg_delay(cfg_delay),
   .cfg_test(cfg_test), .nib_out(nib_out));

// File: tb/nibble_out_stage_tb_top.sv
module nibble_out_stage_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 6;

   localparam logic [15:0] V_WORD [NV] = '{16'hA5C3, 16'h1234, 16'hF00F, 16'h8421, 16'h0000, 16'h5A96};
   localparam logic        V_INV  [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
   localparam logic        V_FAST [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
   localparam logic [1:0]  V_DLY  [NV] = '{2'd0, 2'd1, 2'd2, 2'd0, 2'd3, 2'd3};
   localparam logic [15:0] V_EXP  [NV] = '{16'hA5C3, 16'hEDCB, 16'hF00F, 16'h8421, 16'hFFFF, 16'h5A96};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_valid = 1'b0;
   logic [15:0] smp_word = '0;
   logic        cfg_invert = 1'b0;
   logic        cfg_fast = 1'b0;
   logic [1:0]  cfg_delay = '0;
   logic        cfg_test = 1'b0;
   logic [3:0]  nib_out;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   nibble_out_stage dut_i (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_word(smp_word),
      .cfg_invert(cfg_invert), .cfg_fast(cfg_fast), .cfg_delay(cfg_delay),
      .cfg_test(cfg_test), .nib_out(nib_out));

   task automatic chk(input string tag, input logic [3:0] exp);
      n_checks++;
      if (nib_out !== exp) begin
         n_fail++;
         $display("FAIL %s: nib_out=%h expected=%h", tag, nib_out, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not end, actual=hung expected=done");
         summary();
         $finish;
      end
   end

   initial begin
      logic [3:0] prev;
      int lat;
      repeat (3) @(negedge clk);
      chk("R8 reset value", 4'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R8 zero after reset", 4'h0);
      prev = 4'h0;

      // table of vectors: R1 R2 R3 R4 R5 R6 R10
      for (int i = 0; i < NV; i++) begin
         cfg_invert = V_INV[i];
         cfg_fast   = V_FAST[i];
         cfg_delay  = V_DLY[i];
         lat = int'(V_DLY[i]) * (V_FAST[i] ? 3 : 2);
         @(negedge clk);
         smp_valid = 1'b1;
         smp_word  = V_WORD[i];
         @(negedge clk);
         smp_valid = 1'b0;
         smp_word  = 16'hDEAD;
         repeat (lat) @(negedge clk);
         chk($sformatf("R3/R4/R5 not early vec%0d", i), prev);
         @(negedge clk); chk($sformatf("R1/R2/R6 nibble A vec%0d", i), V_EXP[i][15:12]);
         @(negedge clk); chk($sformatf("R1 nibble B vec%0d", i), V_EXP[i][11:8]);
         @(negedge clk); chk($sformatf("R1 nibble C vec%0d", i), V_EXP[i][7:4]);
         @(negedge clk); chk($sformatf("R1 nibble D vec%0d", i), V_EXP[i][3:0]);
         repeat (3) @(negedge clk);
         chk($sformatf("R10 hold vec%0d", i), V_EXP[i][3:0]);
         prev = V_EXP[i][3:0];
         repeat (12) @(negedge clk);
      end

      // R9: two words two cycles apart
      cfg_invert = 1'b0; cfg_fast = 1'b0; cfg_delay = 2'd0;
      @(negedge clk); smp_valid = 1'b1; smp_word = 16'h1357;
      @(negedge clk); smp_valid = 1'b0;
      @(negedge clk); chk("R9 w1 A", 4'h1); smp_valid = 1'b1; smp_word = 16'h9BDF;
      @(negedge clk); chk("R9 w1 B", 4'h3); smp_valid = 1'b0;
      @(negedge clk); chk("R9 w1 C", 4'h5);
      @(negedge clk); chk("R9 w1 D", 4'h7);
      @(negedge clk); chk("R9 w2 A", 4'h9);
      @(negedge clk); chk("R9 w2 B", 4'hB);
      @(negedge clk); chk("R9 w2 C", 4'hD);
      @(negedge clk); chk("R9 w2 D", 4'hF);
      repeat (12) @(negedge clk);

      // R7: test strobes, normal mode
      cfg_test = 1'b1; smp_word = 16'h0000;
      @(negedge clk); smp_valid = 1'b1;
      @(negedge clk); smp_valid = 1'b0; chk("R7 normal phase0", 4'hA);
      @(negedge clk); chk("R7 normal phase1", 4'h5);
      @(negedge clk); chk("R7 normal wrap", 4'h2);
      repeat (12) @(negedge clk);
      // R7: test strobes, fast mode
      cfg_fast = 1'b1;
      @(negedge clk); smp_valid = 1'b1;
      @(negedge clk); smp_valid = 1'b0; chk("R7 fast phase0", 4'hA);
      @(negedge clk); chk("R7 fast phase1", 4'h4);
      @(negedge clk); chk("R7 fast phase2", 4'h1);
      @(negedge clk); chk("R7 fast wrap", 4'h2);
      repeat (12) @(negedge clk);
      cfg_test = 1'b0;
      #1;
      chk("R7 data restored", 4'h0);

      repeat (4) @(negedge clk);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule